// File: doc/BRIEF.md
# Dual-Clock Mixed-Width Simple Dual-Port RAM

This block is a memory with one write-only port and one read-only port. Each port has its own clock and its own address bus, and the two clocks may be fully unrelated. The write and read data widths may differ by a power-of-two factor. Both ports address the same total number of bits, so a wide word on one side covers a run of consecutive narrow words on the other side.

Storage is split into lanes, each as wide as the narrower port. The wide port reaches every lane at one row. The narrow port picks one lane using the low bits of its address and one row using the remaining bits. Read data comes out of a register in the read clock domain. That register loads only while read enable is high, so a result stays on the output until the next enabled read. The size and ratio parameters are checked at elaboration.

When a read and a write reach the same location on their separate clocks at almost the same time, the read result is undefined. The block gives no old-data or new-data guarantee for that case.

Top module: `mw_sdp_ram`

## Requirements
- R1: With a narrow write port and a wide read port, wide read word k holds narrow words k*R through k*R+R-1, where R is the width ratio. The lowest-addressed narrow word occupies the least significant bits. With the defaults (32 words of 32 bits written, 16 words of 64 bits read), word k is {w[2k+1], w[2k]}.
- R2: A narrow write changes only the one lane chosen by its low address bits. The other lanes of the same wide word keep their contents.
- R3: With a wide write port and a narrow read port, narrow read address a returns bits [(a mod R)*RD_WIDTH +: RD_WIDTH] of wide word a/R.
- R4: Read data appears after the first read-clock rising edge at which read enable is high with the address presented. Before that edge the output still shows the previous result.
- R5: While read enable is low, the read output holds its last value, even when the addressed location is written in the meantime.
- R6: Asserting the active-low asynchronous reset forces the read output to zero. Memory contents survive the reset.
- R7: No location changes while write enable is low, whatever the write address and data do.
- R8: With equal widths (32 words of 8 bits on both ports), the block acts as a plain two-clock memory: each address reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk_i | input | 1 | Write clock |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | $clog2(WR_DEPTH) | Write word address |
| wr_data_i | input | WR_WIDTH | Write data |
| rd_clk_i | input | 1 | Read clock, independent of wr_clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset of the read output |
| rd_en_i | input | 1 | Read enable |
| rd_addr_i | input | $clog2(RD_DEPTH) | Read word address |
| rd_data_o | output | RD_WIDTH | Registered read data |

## Verification
The narrow-to-wide configuration is first filled with a counting pattern in ascending address order. It is then filled again with a walking-one pattern in descending order, which shows that word placement depends on the address and not on the order of the writes. A single overwrite of an odd narrow address, and a burst of address and data changes with write enable low, separate a lane decode that is correct from one that is swapped or too broad. A wide-to-narrow instance and an equal-width instance show that both the even and the odd halves come back in the right order, and that the ratio-one case is still plain memory. Latency and hold are checked by looking at the output just before and just after the capturing edge, and by writing the held location while read enable is low.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int unsigned ratio_of(input int unsigned a, input int unsigned b);
    return (a >= b) ? a / b : b / a;
  endfunction

endpackage

// File: rtl/mwram_bank.sv
module mwram_bank #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          wr_clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/mwram_wr_steer.sv
module mwram_wr_steer #(
  parameter int WR_AW  = 5,
  parameter int LANES  = 2,
  parameter int LSEL_W = 1,
  parameter int ROW_AW = 4,
  parameter bit NARROW = 1'b1
) (
  input  logic              wr_en_i,
  input  logic [WR_AW-1:0]  wr_addr_i,
  output logic [LANES-1:0]  lane_we_o,
  output logic [ROW_AW-1:0] row_o
);

  if (NARROW && (LANES > 1)) begin : g_split
    // low address bits pick the lane, upper bits the row
    assign row_o = wr_addr_i[WR_AW-1:LSEL_W];
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign lane_we_o[j] = wr_en_i && (wr_addr_i[LSEL_W-1:0] == LSEL_W'(j));
    end
  end else begin : g_whole
    assign row_o     = wr_addr_i;
    assign lane_we_o = {LANES{wr_en_i}};
  end

endmodule

// File: rtl/mwram_rd_select.sv
module mwram_rd_select #(
  parameter int UNIT_W = 32,
  parameter int LANES  = 2,
  parameter int LSEL_W = 1,
  parameter int RD_AW  = 5,
  parameter int ROW_AW = 4
) (
  input  logic                         rd_clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_en_i,
  input  logic [RD_AW-1:0]             rd_addr_i,
  input  logic [LANES-1:0][UNIT_W-1:0] lane_q_i,
  output logic [ROW_AW-1:0]            row_o,
  output logic [UNIT_W-1:0]            rd_data_o
);

  logic [LSEL_W-1:0] sel_q;

  assign row_o = rd_addr_i[RD_AW-1:LSEL_W];

  // lane select follows the bank output register: same clock, same enable
  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (rd_en_i) sel_q <= rd_addr_i[LSEL_W-1:0];
  end

  assign rd_data_o = lane_q_i[sel_q];

endmodule

// File: rtl/mw_sdp_ram.sv
module mw_sdp_ram
  import mwram_pkg::*;
#(
  parameter int WR_WIDTH = 32,
  parameter int WR_DEPTH = 32,
  parameter int RD_WIDTH = 64,
  parameter int RD_DEPTH = 16
) (
  input  logic                        wr_clk_i,
  input  logic                        wr_en_i,
  input  logic [$clog2(WR_DEPTH)-1:0] wr_addr_i,
  input  logic [WR_WIDTH-1:0]         wr_data_i,
  input  logic                        rd_clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_en_i,
  input  logic [$clog2(RD_DEPTH)-1:0] rd_addr_i,
  output logic [RD_WIDTH-1:0]         rd_data_o
);

  localparam bit WR_NARROW = (WR_WIDTH <= RD_WIDTH);
  localparam int UNIT_W    = WR_NARROW ? WR_WIDTH : RD_WIDTH;
  localparam int LANES     = int'(ratio_of(WR_WIDTH, RD_WIDTH));
  localparam int LSEL_W    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int ROWS      = WR_NARROW ? RD_DEPTH : WR_DEPTH;
  localparam int WR_AW     = $clog2(WR_DEPTH);
  localparam int RD_AW     = $clog2(RD_DEPTH);
  localparam int ROW_AW    = $clog2(ROWS);

  if (WR_WIDTH * WR_DEPTH != RD_WIDTH * RD_DEPTH) begin : g_bad_size
    $error("mw_sdp_ram: write and read sides cover different storage");
  end
  if (!is_pow2(LANES) || (LANES * UNIT_W != (WR_NARROW ? RD_WIDTH : WR_WIDTH))) begin : g_bad_ratio
    $error("mw_sdp_ram: width ratio is not a power of two");
  end
  if (!is_pow2(WR_DEPTH) || !is_pow2(RD_DEPTH) || ROWS < 2) begin : g_bad_depth
    $error("mw_sdp_ram: depths must be powers of two of at least 2 rows");
  end

  logic [LANES-1:0]             lane_we;
  logic [LANES-1:0][UNIT_W-1:0] lane_wd;
  logic [LANES-1:0][UNIT_W-1:0] lane_q;
  logic [ROW_AW-1:0]            wr_row;
  logic [ROW_AW-1:0]            rd_row;

  mwram_wr_steer #(
    .WR_AW (WR_AW),
    .LANES (LANES),
    .LSEL_W(LSEL_W),
    .ROW_AW(ROW_AW),
    .NARROW(WR_NARROW)
  ) u_steer (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .lane_we_o(lane_we),
    .row_o    (wr_row)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_bank
    if (WR_NARROW) begin : g_wd_bcast
      assign lane_wd[j] = wr_data_i;
    end else begin : g_wd_slice
      assign lane_wd[j] = wr_data_i[j*UNIT_W +: UNIT_W];
    end

    mwram_bank #(
      .W    (UNIT_W),
      .DEPTH(ROWS),
      .AW   (ROW_AW)
    ) u_bank (
      .wr_clk_i(wr_clk_i),
      .we_i    (lane_we[j]),
      .waddr_i (wr_row),
      .wdata_i (lane_wd[j]),
      .rd_clk_i(rd_clk_i),
      .rst_ni  (rst_ni),
      .re_i    (rd_en_i),
      .raddr_i (rd_row),
      .rdata_o (lane_q[j])
    );
  end

  if (WR_NARROW) begin : g_rd_wide
    // lane 0 lands in the least significant bits
    assign rd_row    = rd_addr_i;
    assign rd_data_o = lane_q;
  end else begin : g_rd_narrow
    mwram_rd_select #(
      .UNIT_W(UNIT_W),
      .LANES (LANES),
      .LSEL_W(LSEL_W),
      .RD_AW (RD_AW),
      .ROW_AW(ROW_AW)
    ) u_rsel (
      .rd_clk_i (rd_clk_i),
      .rst_ni   (rst_ni),
      .rd_en_i  (rd_en_i),
      .rd_addr_i(rd_addr_i),
      .lane_q_i (lane_q),
      .row_o    (rd_row),
      .rd_data_o(rd_data_o)
    );
  end

endmodule

// File: rtl/mwram_chk.sv
module mwram_chk #(
  parameter int LANES     = 2,
  parameter bit WR_NARROW = 1'b1,
  parameter int RD_WIDTH  = 64
) (
  input logic                wr_clk_i,
  input logic                rd_clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [LANES-1:0]    lane_we,
  input logic [RD_WIDTH-1:0] rd_data_o
);

  // R2: a narrow write reaches exactly one lane
  a_r2_one_lane: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_en_i && WR_NARROW) |-> ($countones(lane_we) == 1));

  // R3: a wide write reaches every lane
  a_r3_all_lanes: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_en_i && !WR_NARROW) |-> ($countones(lane_we) == LANES));

  // R7: no lane strobe without write enable
  a_r7_no_stray_we: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (lane_we == '0));

  // R5: output held while read enable is low
  a_r5_hold_idle: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R6: output cleared while in reset
  always @(posedge rd_clk_i) begin
    if (!rst_ni) begin
      a_r6_reset_zero: assert (rd_data_o == '0);
    end
  end

endmodule

bind mw_sdp_ram mwram_chk #(
  .LANES    (LANES),
  .WR_NARROW(WR_NARROW),
  .RD_WIDTH (RD_WIDTH)
) u_chk (
  .wr_clk_i (wr_clk_i),
  .rd_clk_i (rd_clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .lane_we  (lane_we),
  .rd_data_o(rd_data_o)
);

// File: tb/mw_sdp_ram_tb.sv
`timescale 1ns/100ps
module mw_sdp_ram_tb;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst_ni = 1'b1;
  always #4   wr_clk = ~wr_clk;   // 125 MHz
  always #6.5 rd_clk = ~rd_clk;   // unrelated read clock

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // narrow write, wide read
  logic        w0_en = 1'b0, r0_en = 1'b0;
  logic [4:0]  w0_addr = '0;
  logic [31:0] w0_data = '0;
  logic [3:0]  r0_addr = '0;
  logic [63:0] r0_data;
  // wide write, narrow read
  logic        w1_en = 1'b0, r1_en = 1'b0;
  logic [3:0]  w1_addr = '0;
  logic [63:0] w1_data = '0;
  logic [4:0]  r1_addr = '0;
  logic [31:0] r1_data;
  // equal widths
  logic        w2_en = 1'b0, r2_en = 1'b0;
  logic [4:0]  w2_addr = '0, r2_addr = '0;
  logic [7:0]  w2_data = '0;
  logic [7:0]  r2_data;

  logic [31:0] m0 [32];
  logic [63:0] m1 [16];
  logic [7:0]  m2 [32];

  mw_sdp_ram u_dut (
    .wr_clk_i(wr_clk), .wr_en_i(w0_en), .wr_addr_i(w0_addr), .wr_data_i(w0_data),
    .rd_clk_i(rd_clk), .rst_ni(rst_ni), .rd_en_i(r0_en), .rd_addr_i(r0_addr),
    .rd_data_o(r0_data));

  mw_sdp_ram #(.WR_WIDTH(64), .WR_DEPTH(16), .RD_WIDTH(32), .RD_DEPTH(32)) u_dut_wide_wr (
    .wr_clk_i(wr_clk), .wr_en_i(w1_en), .wr_addr_i(w1_addr), .wr_data_i(w1_data),
    .rd_clk_i(rd_clk), .rst_ni(rst_ni), .rd_en_i(r1_en), .rd_addr_i(r1_addr),
    .rd_data_o(r1_data));

  mw_sdp_ram #(.WR_WIDTH(8), .WR_DEPTH(32), .RD_WIDTH(8), .RD_DEPTH(32)) u_dut_eq (
    .wr_clk_i(wr_clk), .wr_en_i(w2_en), .wr_addr_i(w2_addr), .wr_data_i(w2_data),
    .rd_clk_i(rd_clk), .rst_ni(rst_ni), .rd_en_i(r2_en), .rd_addr_i(r2_addr),
    .rd_data_o(r2_data));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr0(input logic [4:0] a, input logic [31:0] d);
    @(negedge wr_clk); w0_addr = a; w0_data = d; w0_en = 1'b1;
    @(negedge wr_clk); w0_en = 1'b0;
    m0[a] = d;
  endtask

  task automatic rd0(input logic [3:0] a, output logic [63:0] q);
    @(negedge rd_clk); r0_addr = a; r0_en = 1'b1;
    @(negedge rd_clk); r0_en = 1'b0; q = r0_data;
  endtask

  function automatic logic [63:0] exp0(input int k);
    return {m0[2*k+1], m0[2*k]};
  endfunction

  task automatic t_reset();
    chk("R6 reset main", r0_data, 64'h0);
    chk("R6 reset wide_wr", {32'h0, r1_data}, 64'h0);
    chk("R6 reset eq", {56'h0, r2_data}, 64'h0);
  endtask

  task automatic t_ascending();
    logic [63:0] q;
    for (int i = 0; i < 32; i++) wr0(5'(i), {8'hA5, 8'(i), 8'(~i), 8'(i * 3)});
    for (int k = 0; k < 16; k++) begin
      rd0(4'(k), q);
      chk($sformatf("R1 ascending k=%0d", k), q, exp0(k));
    end
  endtask

  task automatic t_descending();
    logic [63:0] q;
    for (int i = 31; i >= 0; i--) wr0(5'(i), 32'h1 << i);
    for (int k = 15; k >= 0; k--) begin
      rd0(4'(k), q);
      chk($sformatf("R1 walking k=%0d", k), q, exp0(k));
    end
  endtask

  task automatic t_single_lane();
    logic [63:0] q;
    wr0(5'd7, 32'hDEAD_BEEF);
    rd0(4'd3, q);
    chk("R2 odd lane write", q, {32'hDEAD_BEEF, m0[6]});
    wr0(5'd8, 32'h0BAD_F00D);
    rd0(4'd4, q);
    chk("R2 even lane write", q, {m0[9], 32'h0BAD_F00D});
  endtask

  task automatic t_wr_disabled();
    logic [63:0] q;
    for (int i = 0; i < 6; i++) begin
      @(negedge wr_clk); w0_en = 1'b0; w0_addr = 5'(4 + (i % 2)); w0_data = 32'h5555_0000 + i;
    end
    rd0(4'd2, q);
    chk("R7 no write when disabled", q, exp0(2));
  endtask

  task automatic t_latency();
    logic [63:0] q;
    rd0(4'd1, q);
    @(negedge rd_clk); r0_addr = 4'd0; r0_en = 1'b1;
    #1 chk("R4 not before edge", r0_data, exp0(1));
    @(negedge rd_clk); r0_en = 1'b0;
    chk("R4 after one edge", r0_data, exp0(0));
  endtask

  task automatic t_hold();
    logic [63:0] q, held;
    rd0(4'd5, held);
    @(negedge rd_clk); r0_addr = 4'd9; r0_en = 1'b0;
    wr0(5'd10, 32'h7777_1234);
    repeat (3) @(negedge rd_clk);
    chk("R5 held while idle", r0_data, held);
    rd0(4'd5, q);
    chk("R5 fresh read after hold", q, exp0(5));
  endtask

  task automatic t_midreset();
    logic [63:0] q;
    @(negedge rd_clk); rst_ni = 1'b0;
    #2 chk("R6 async clear", r0_data, 64'h0);
    @(negedge rd_clk); rst_ni = 1'b1;
    rd0(4'd3, q);
    chk("R6 contents kept", q, exp0(3));
  endtask

  task automatic t_wide_write();
    for (int k = 0; k < 16; k++) begin
      m1[k] = {32'hC0DE_0000 | 32'(k), 32'h0000_BEEF ^ (32'(k) << 16)};
      @(negedge wr_clk); w1_addr = 4'(k); w1_data = m1[k]; w1_en = 1'b1;
      @(negedge wr_clk); w1_en = 1'b0;
    end
    for (int a = 0; a < 32; a++) begin
      @(negedge rd_clk); r1_addr = 5'(a); r1_en = 1'b1;
      @(negedge rd_clk); r1_en = 1'b0;
      chk($sformatf("R3 narrow read a=%0d", a), {32'h0, r1_data},
          {32'h0, m1[a / 2][(a % 2) * 32 +: 32]});
    end
  endtask

  task automatic t_equal();
    for (int i = 0; i < 32; i++) begin
      m2[i] = 8'(i * 7 + 1);
      @(negedge wr_clk); w2_addr = 5'(i); w2_data = m2[i]; w2_en = 1'b1;
      @(negedge wr_clk); w2_en = 1'b0;
    end
    for (int i = 31; i >= 0; i--) begin
      @(negedge rd_clk); r2_addr = 5'(i); r2_en = 1'b1;
      @(negedge rd_clk); r2_en = 1'b0;
      chk($sformatf("R8 equal width a=%0d", i), {56'h0, r2_data}, {56'h0, m2[i]});
    end
  endtask

  initial begin
    #3 rst_ni = 1'b0;
    #40 rst_ni = 1'b1;
    t_reset();
    t_ascending();
    t_descending();
    t_single_lane();
    t_wr_disabled();
    t_latency();
    t_hold();
    t_midreset();
    t_wide_write();
    t_equal();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule